// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative reference into a flat 20-bit physical address. It keeps four 16-bit segment bases, one each for code, data, stack and extra storage, which can be loaded through a single write port. A requester presents an access-kind code together with all of its current offset sources: instruction pointer, stack pointer, base pointer, effective address, source index and destination index.

From the access kind alone the block selects the base register and the offset, with no override. It places the base four bit positions up, adds the offset, and delivers the sum on a registered output with a one-cycle valid pulse. String moves are split into two kinds, because the source side and the destination side use different base and index pairs. Because every base is a multiple of sixteen bytes, the low nibble of the result always comes straight from the offset. A sum beyond the top of the 1 MiB space wraps around to the bottom.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, addr_valid is 0 and addr_out is 0. The code base resets to FFFF hex and the data, stack and extra bases reset to 0000.
- R2: When req_valid is 1 with a legal req_kind, addr_out shows (base << 4) + offset one clock later, and addr_valid is 1 in that cycle only.
- R3: The addition is taken modulo 2^20, so any carry past bit 19 is dropped. For example, base FFFF with offset 0010 gives 00000.
- R4: req_kind 0 (instruction fetch) uses the code base with ip_in.
- R5: req_kind 1 (stack push or pop) uses the stack base with sp_in. req_kind 2 (base-pointer access) uses the stack base with bp_in.
- R6: req_kind 3 (data operand) uses the data base with ea_in.
- R7: req_kind 4 (string source) uses the data base with si_in. req_kind 5 (string destination) uses the extra base with di_in.
- R8: A base write takes effect at the clock edge. A request in the same cycle as the write uses the old base, and the next request uses the new one.
- R9: A request with req_kind 6 or 7 is ignored. addr_valid stays 0 and addr_out keeps its value.
- R10: In a cycle with no request, addr_valid is 0 on the following cycle and addr_out holds its value.
- R11: The write port selects the base by seg_wr_sel: 0 selects code, 1 data, 2 stack and 3 extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Load the selected segment base |
| seg_wr_sel | input | 2 | Base select: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | New base value |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 3 | Access kind code (0 to 5 legal) |
| ip_in | input | 16 | Instruction pointer offset |
| sp_in | input | 16 | Stack pointer offset |
| bp_in | input | 16 | Base pointer offset |
| ea_in | input | 16 | Effective address offset |
| si_in | input | 16 | Source index offset |
| di_in | input | 16 | Destination index offset |
| addr_valid | output | 1 | One-cycle pulse marking a new address |
| addr_out | output | 20 | Registered physical address |

## Verification
Each legal access kind is tried while the six offset inputs carry six different values. A wrong choice of offset or base therefore produces a different address instead of a matching one. The bases are then given distinct values so that the code, data, stack and extra routes can be told apart. The offset values include all-ones and cases whose sum carries past bit 19, which separates a correct modulo-2^20 adder from one that saturates or keeps a 21st bit. Directed cases show that the bases reset to their stated values, that a write in the same cycle as a request does not reach that request, and that the illegal kinds and the idle cycles leave the output unchanged.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int NUM_SEG = 4;
    localparam int KIND_W  = 3;
    localparam int ADDR_W  = SEG_W + SHIFT;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_sel_e;

    typedef enum logic [KIND_W-1:0] {
        ACC_FETCH   = 3'd0,
        ACC_STACK   = 3'd1,
        ACC_BASEPTR = 3'd2,
        ACC_DATA    = 3'd3,
        ACC_STR_SRC = 3'd4,
        ACC_STR_DST = 3'd5,
        ACC_RSVD6   = 3'd6,
        ACC_RSVD7   = 3'd7
    } acc_kind_e;

    typedef struct packed {
        logic             legal;
        seg_sel_e         seg;
        logic [OFF_W-1:0] off;
    } route_t;

    function automatic logic [SEG_W-1:0] seg_reset_value(input int idx);
        return (idx == int'(SEG_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
    endfunction

    function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                    input logic [OFF_W-1:0] off);
        logic [ADDR_W-1:0] base;
        base = {seg, {SHIFT{1'b0}}};
        return base + ADDR_W'(off);
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  seg_sel_e         rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[g] <= seg_reset_value(g);
            else if (wr_en && wr_sel == SEL_W'(g))
                seg_q[g] <= wr_data;
        end

        // R8 / R11: the selected base takes the written value at the next edge
        a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEL_W'(g)) |=> seg_q[g] == $past(wr_data));

        // R8: an unselected base keeps its value
        a_r8_others_keep: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(seg_q[g]));
    end

    assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_route.sv
module seg_route
    import seg_addr_pkg::*;
(
    input  acc_kind_e        kind,
    input  logic [OFF_W-1:0] ip_off,
    input  logic [OFF_W-1:0] sp_off,
    input  logic [OFF_W-1:0] bp_off,
    input  logic [OFF_W-1:0] ea_off,
    input  logic [OFF_W-1:0] si_off,
    input  logic [OFF_W-1:0] di_off,
    output route_t           route
);

    always_comb begin
        route.legal = 1'b1;
        route.seg   = SEG_DATA;
        route.off   = ea_off;
        unique case (kind)
            ACC_FETCH:   begin route.seg = SEG_CODE;  route.off = ip_off; end
            ACC_STACK:   begin route.seg = SEG_STACK; route.off = sp_off; end
            ACC_BASEPTR: begin route.seg = SEG_STACK; route.off = bp_off; end
            ACC_DATA:    begin route.seg = SEG_DATA;  route.off = ea_off; end
            ACC_STR_SRC: begin route.seg = SEG_DATA;  route.off = si_off; end
            ACC_STR_DST: begin route.seg = SEG_EXTRA; route.off = di_off; end
            default:     route.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_stage.sv
module addr_stage
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr_q,
    output logic              valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept)
                addr_q <= phys_addr(seg_val, offset);
        end
    end

    // R2: an accepted request produces exactly one valid cycle, one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> valid_q);

    // R10: without a request the output holds and valid is low
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!valid_q && $stable(addr_q)));

    // R3: bases sit on 16-byte boundaries, so the low nibble is the offset's
    a_r3_low_nibble: assert property (@(posedge clk) disable iff (rst)
        accept |=> addr_q[SHIFT-1:0] == $past(offset[SHIFT-1:0]));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [OFF_W-1:0]  ip_in,
    input  logic [OFF_W-1:0]  sp_in,
    input  logic [OFF_W-1:0]  bp_in,
    input  logic [OFF_W-1:0]  ea_in,
    input  logic [OFF_W-1:0]  si_in,
    input  logic [OFF_W-1:0]  di_in,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr_out
);

    route_t           route;
    logic [SEG_W-1:0] seg_val;
    logic             accept;

    seg_route u_route (
        .kind   (acc_kind_e'(req_kind)),
        .ip_off (ip_in),
        .sp_off (sp_in),
        .bp_off (bp_in),
        .ea_off (ea_in),
        .si_off (si_in),
        .di_off (di_in),
        .route  (route)
    );

    seg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (route.seg),
        .rd_data (seg_val)
    );

    assign accept = req_valid && route.legal;

    addr_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .seg_val (seg_val),
        .offset  (route.off),
        .addr_q  (addr_out),
        .valid_q (addr_valid)
    );

    // R9: reserved kinds never raise the valid strobe nor move the address
    a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind >= KIND_W'(6)) |=> (!addr_valid && $stable(addr_out)));

    // R2: valid never appears unless a request was present the cycle before
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> $past(req_valid));

endmodule

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [15:0] ip_in, sp_in, bp_in, ea_in, si_in, di_in;
    logic        addr_valid;
    logic [19:0] addr_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst(rst),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_kind(req_kind),
        .ip_in(ip_in), .sp_in(sp_in), .bp_in(bp_in),
        .ea_in(ea_in), .si_in(si_in), .di_in(di_in),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    // kind[38:36], offset[35:20], expected[19:0]; bases CS=456A DS=1000 SS=2345 ES=FFFF
    localparam logic [38:0] VECS [10] = '{
        {3'd0, 16'h1620, 20'h46CC0},   // R4
        {3'd0, 16'hFFFF, 20'h5569F},   // R4
        {3'd1, 16'h0100, 20'h23550},   // R5
        {3'd2, 16'h8001, 20'h2B451},   // R5
        {3'd3, 16'hFFFF, 20'h1FFFF},   // R6
        {3'd3, 16'h0007, 20'h10007},   // R6
        {3'd4, 16'h0042, 20'h10042},   // R7
        {3'd5, 16'h0010, 20'h00000},   // R7, R3 wrap
        {3'd5, 16'h1234, 20'h01224},   // R7, R3 wrap
        {3'd5, 16'h000F, 20'hFFFFF}    // R7, top of space
    };

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive_req(input logic [2:0] k, input logic [15:0] o);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        ip_in = 16'h1111; sp_in = 16'h2222; bp_in = 16'h3333;
        ea_in = 16'h4444; si_in = 16'h5555; di_in = 16'h6666;
        case (k)
            3'd0: ip_in = o;
            3'd1: sp_in = o;
            3'd2: bp_in = o;
            3'd3: ea_in = o;
            3'd4: si_in = o;
            3'd5: di_in = o;
            default: ;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
        seg_wr_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        req_valid   = 1'b0;
        seg_wr_en   = 1'b1;
        seg_wr_sel  = sel;
        seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        rst = 1'b1; seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h0;
        req_valid = 1'b0; req_kind = 3'd0;
        ip_in = 0; sp_in = 0; bp_in = 0; ea_in = 0; si_in = 0; di_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 valid after reset", {19'd0, addr_valid}, 20'd0);
        check("R1 addr after reset", addr_out, 20'd0);

        // R1: reset base values seen through requests
        drive_req(3'd0, 16'h0000);
        check("R1 code base FFFF", addr_out, 20'hFFFF0);
        drive_req(3'd3, 16'h0000);
        check("R1 data base zero", addr_out, 20'h00000);
        drive_req(3'd1, 16'h0012);
        check("R1 stack base zero", addr_out, 20'h00012);
        drive_req(3'd5, 16'h0034);
        check("R1 extra base zero", addr_out, 20'h00034);
        go_idle();

        // R11: load bases by selector code
        wr_seg(2'd0, 16'h456A);
        wr_seg(2'd1, 16'h1000);
        wr_seg(2'd2, 16'h2345);
        wr_seg(2'd3, 16'hFFFF);

        for (int i = 0; i < 10; i++) begin
            drive_req(VECS[i][38:36], VECS[i][35:20]);
            check($sformatf("R2 vector %0d valid", i), {19'd0, addr_valid}, 20'd1);
            check($sformatf("R2 vector %0d kind %0d addr", i, VECS[i][38:36]),
                  addr_out, VECS[i][19:0]);
            go_idle();
            check($sformatf("R10 vector %0d valid drops", i), {19'd0, addr_valid}, 20'd0);
            check($sformatf("R10 vector %0d addr holds", i), addr_out, VECS[i][19:0]);
        end

        // R8: write and request in the same cycle use the old data base
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h2000;
        req_valid = 1'b1; req_kind = 3'd3; ea_in = 16'h0005;
        @(posedge clk);
        #1;
        check("R8 same-cycle old base", addr_out, 20'h10005);
        go_idle();
        drive_req(3'd3, 16'h0005);
        check("R8 next request new base", addr_out, 20'h20005);
        go_idle();

        // R9: reserved kinds 6 and 7
        held = addr_out;
        drive_req(3'd6, 16'h0000);
        check("R9 kind 6 no valid", {19'd0, addr_valid}, 20'd0);
        check("R9 kind 6 addr unchanged", addr_out, held);
        drive_req(3'd7, 16'h0000);
        check("R9 kind 7 no valid", {19'd0, addr_valid}, 20'd0);
        check("R9 kind 7 addr unchanged", addr_out, held);
        go_idle();

        // R2: back-to-back requests, each valid
        drive_req(3'd4, 16'h0001);
        check("R2 back-to-back first", addr_out, 20'h20001);
        drive_req(3'd2, 16'h0002);
        check("R2 back-to-back second", addr_out, 20'h23452);
        check("R2 back-to-back valid", {19'd0, addr_valid}, 20'd1);
        go_idle();

        // R1: reset again clears the output and restores the code base
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 addr cleared by reset", addr_out, 20'd0);
        drive_req(3'd0, 16'h0001);
        check("R1 code base restored", addr_out, 20'hFFFF1);
        go_idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule